// File: doc/BRIEF.md
# Packet Sequence and LCRC Framer

The framer sits on the transmit side of a link layer. Upstream logic hands it transaction packets as streams of 32-bit words marked with start and end flags. For each new packet the block emits a header word carrying a 12-bit link sequence number, then the packet body, then a 32-bit link CRC word. The CRC covers the header's low 16 bits (four reserved zero bits above the sequence number) and every body word. A copy of each new packet's header and body goes to a replay store on a separate output, so that packets that are not acknowledged can be sent again later.

When the replay mode input is high at a packet boundary, the framer takes its input from the replay store port instead. A replayed packet arrives with its stored header word already in place. The framer passes that header through unchanged, forwards the body, and computes a fresh CRC over the result. Replayed packets do not move the sequence counter and are not copied back to the store. Both the inputs and the output use a valid/ready handshake, and output backpressure freezes the whole pipeline without harming the running CRC.

Top module: `seq_lcrc_framer`

## Requirements
- R1: After synchronous reset the sequence number is 0, `out_valid` and `store_valid` are low while no input is offered, and the first new packet carries sequence 0.
- R2: A new packet of N body words leaves as N+2 output words. Word 0 is the header, equal to the sequence number zero-extended to 32 bits, with `out_sop` set. Words 1..N are the body words unchanged. Word N+1 is the CRC, with `out_eop` set. No word has both flags set.
- R3: The CRC is MSB-first over polynomial 0x04C11DB7 with a seed of 0xFFFFFFFF. It covers header bits 15..0 and then each body word from bit 31 down to bit 0. The final value is inverted before it is sent.
- R4: The sequence number rises by one, modulo 4096, in the cycle after the last body word of a new packet is accepted, and at no other time. After 0xFFF comes 0.
- R5: Each header and body word of a new packet also appears on `store_data`. It appears in the same cycle as its output transfer, with `store_sop` on the header and `store_eop` on the last body word. The CRC word is never copied to the store.
- R6: In replay mode, the first replay word (which has `rpl_in_sop` set) is emitted unchanged as the header. The body follows and a freshly computed CRC ends the packet. `store_valid` stays low and the sequence counter does not change.
- R7: The source is chosen from `replay_mode` only when a packet starts. A change of `replay_mode` while a packet is in flight has no effect until that packet's CRC word has left.
- R8: While `out_valid` is high and `out_ready` is low, the output word and flags stay stable and no input word is accepted. The CRC is correct however the stalls fall.
- R9: At most one of `new_ready` and `rpl_in_ready` is high in any cycle. The source that is not selected is never ready.
- R10: Between packets, an input word on the selected source without its start flag is accepted and discarded. It produces no output and no store copy, and the sequence number does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high link reset |
| replay_mode | input | 1 | 1 selects the replay store as source for the next packet |
| new_valid | input | 1 | New packet word valid |
| new_ready | output | 1 | New packet word accepted |
| new_data | input | 32 | New packet body word |
| new_sop | input | 1 | First word of a new packet |
| new_eop | input | 1 | Last word of a new packet |
| rpl_in_valid | input | 1 | Replay word valid |
| rpl_in_ready | output | 1 | Replay word accepted |
| rpl_in_data | input | 32 | Replay word (stored header first, then body) |
| rpl_in_sop | input | 1 | Stored header word of a replayed packet |
| rpl_in_eop | input | 1 | Last body word of a replayed packet |
| out_valid | output | 1 | Framed word valid |
| out_ready | input | 1 | Downstream accepts the framed word |
| out_data | output | 32 | Framed word: header, body or CRC |
| out_sop | output | 1 | Header word of a framed packet |
| out_eop | output | 1 | CRC word of a framed packet |
| store_valid | output | 1 | Copy of a new packet word for the replay store |
| store_data | output | 32 | Copied header or body word |
| store_sop | output | 1 | Copied word is the header |
| store_eop | output | 1 | Copied word is the last body word |

## Verification
The assertions check, in every cycle, that the sequence counter moves only by a single step and only when a new packet ends. They also check that the two sources are never ready together, that no store copy appears while a replay word is consumed, and that the CRC word holds still under backpressure. Only the bench's scenarios can show that the CRC value matches the polynomial definition, that replayed headers keep their stored number, and that a mode change partway through a packet is ignored. They also show that the counter wraps after 4096 packets and that stray words between packets vanish without effect.

// File: rtl/lcrc_pkg.sv
package lcrc_pkg;

    localparam int WORD_W = 32;
    localparam int SEQ_W  = 12;
    localparam int HDR_W  = 16;
    localparam int CRC_W  = 32;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_BODY = 2'd1,
        ST_CRC  = 2'd2
    } frm_state_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic              sop;
        logic              eop;
    } beat_t;

    // Feed the low nbits of d into the CRC, most significant of them first.
    function automatic logic [CRC_W-1:0] crc_advance(
        input logic [CRC_W-1:0]  c,
        input logic [WORD_W-1:0] d,
        input int unsigned       nbits
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (i < int'(nbits)) begin
                fb = r[CRC_W-1] ^ d[i];
                r  = {r[CRC_W-2:0], 1'b0};
                if (fb) r = r ^ CRC_POLY;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lcrc_seq_counter.sv
module lcrc_seq_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bump,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (bump) value <= value + W'(1);
    end
endmodule

// File: rtl/lcrc_crc_unit.sv
module lcrc_crc_unit
    import lcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_hdr,
    input  logic              step_word,
    input  logic [WORD_W-1:0] word,
    output logic [CRC_W-1:0]  crc
);
    always_ff @(posedge clk) begin
        if (rst)            crc <= CRC_SEED;
        else if (load_hdr)  crc <= crc_advance(CRC_SEED, word, HDR_W);
        else if (step_word) crc <= crc_advance(crc, word, WORD_W);
    end
endmodule

// File: rtl/seq_lcrc_framer.sv
module seq_lcrc_framer
    import lcrc_pkg::*;
#(
    parameter int SQ_W = lcrc_pkg::SEQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              replay_mode,
    input  logic              new_valid,
    output logic              new_ready,
    input  logic [WORD_W-1:0] new_data,
    input  logic              new_sop,
    input  logic              new_eop,
    input  logic              rpl_in_valid,
    output logic              rpl_in_ready,
    input  logic [WORD_W-1:0] rpl_in_data,
    input  logic              rpl_in_sop,
    input  logic              rpl_in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              store_valid,
    output logic [WORD_W-1:0] store_data,
    output logic              store_sop,
    output logic              store_eop
);
    frm_state_e        st_q;
    logic              src_rpl_q;
    logic              use_rpl;
    beat_t             nb, rb, in_b;
    logic              in_ready;
    logic              out_fire;
    logic [SQ_W-1:0]   seq_cur;
    logic [CRC_W-1:0]  crc_q;
    logic [WORD_W-1:0] hdr_word;
    logic              seq_bump;

    // Source is chosen live at a boundary, then frozen for the packet.
    assign use_rpl  = (st_q == ST_HDR) ? replay_mode : src_rpl_q;
    assign nb       = '{valid: new_valid, data: new_data, sop: new_sop, eop: new_eop};
    assign rb       = '{valid: rpl_in_valid, data: rpl_in_data, sop: rpl_in_sop, eop: rpl_in_eop};
    assign in_b     = use_rpl ? rb : nb;
    assign hdr_word = WORD_W'(seq_cur);

    always_comb begin
        out_valid = 1'b0;
        out_data  = in_b.data;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        in_ready  = 1'b0;
        unique case (st_q)
            ST_HDR: begin
                if (!in_b.sop) begin
                    in_ready = 1'b1;              // stray word: drop
                end else begin
                    out_valid = in_b.valid;
                    out_sop   = 1'b1;
                    out_data  = use_rpl ? in_b.data : hdr_word;
                    in_ready  = use_rpl & out_ready;
                end
            end
            ST_BODY: begin
                out_valid = in_b.valid;
                in_ready  = out_ready;
            end
            ST_CRC: begin
                out_valid = 1'b1;
                out_eop   = 1'b1;
                out_data  = ~crc_q;
            end
            default: ;
        endcase
    end

    assign out_fire     = out_valid & out_ready;
    assign new_ready    = in_ready & ~use_rpl;
    assign rpl_in_ready = in_ready &  use_rpl;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_HDR;
            src_rpl_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_HDR:  if (out_fire) begin
                             st_q      <= ST_BODY;
                             src_rpl_q <= use_rpl;
                         end
                ST_BODY: if (out_fire && in_b.eop) st_q <= ST_CRC;
                ST_CRC:  if (out_ready) st_q <= ST_HDR;
                default: st_q <= ST_HDR;
            endcase
        end
    end

    assign seq_bump = (st_q == ST_BODY) & out_fire & in_b.eop & ~src_rpl_q;

    lcrc_seq_counter #(.W(SQ_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .bump  (seq_bump),
        .value (seq_cur)
    );

    lcrc_crc_unit u_crc (
        .clk       (clk),
        .rst       (rst),
        .load_hdr  ((st_q == ST_HDR) & out_fire),
        .step_word ((st_q == ST_BODY) & out_fire),
        .word      (out_data),
        .crc       (crc_q)
    );

    // Replay store copy of new packets, same cycle as the output transfer.
    assign store_valid = out_fire & ~use_rpl & (st_q != ST_CRC);
    assign store_data  = (st_q == ST_HDR) ? hdr_word : new_data;
    assign store_sop   = (st_q == ST_HDR);
    assign store_eop   = (st_q == ST_BODY) & new_eop;

endmodule

// File: rtl/seq_lcrc_framer_checks.sv
module seq_lcrc_framer_checks #(
    parameter int SQ_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            new_valid,
    input logic            new_ready,
    input logic            new_eop,
    input logic            rpl_in_valid,
    input logic            rpl_in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [31:0]     out_data,
    input logic            out_sop,
    input logic            out_eop,
    input logic            store_valid,
    input logic [SQ_W-1:0] seq_cur
);
    logic new_end;
    assign new_end = new_valid & new_ready & new_eop & out_valid;

    a_r4_seq_hold: assert property (@(posedge clk) disable iff (rst)
        !new_end |=> $stable(seq_cur));

    a_r4_seq_step: assert property (@(posedge clk) disable iff (rst)
        new_end |=> seq_cur == SQ_W'($past(seq_cur) + SQ_W'(1)));

    a_r8_crc_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_eop && !out_ready |=> out_valid && out_eop && $stable(out_data));

    a_r9_one_ready: assert property (@(posedge clk) disable iff (rst)
        !(new_ready && rpl_in_ready));

    a_r6_no_store_copy: assert property (@(posedge clk) disable iff (rst)
        rpl_in_valid && rpl_in_ready |-> !store_valid);

    a_r5_store_on_xfer: assert property (@(posedge clk) disable iff (rst)
        store_valid |-> out_valid && out_ready && !out_eop);

    a_r2_flag_excl: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sop && out_eop));
endmodule

bind seq_lcrc_framer seq_lcrc_framer_checks #(.SQ_W(SQ_W)) u_checks (
    .clk          (clk),
    .rst          (rst),
    .new_valid    (new_valid),
    .new_ready    (new_ready),
    .new_eop      (new_eop),
    .rpl_in_valid (rpl_in_valid),
    .rpl_in_ready (rpl_in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_sop      (out_sop),
    .out_eop      (out_eop),
    .store_valid  (store_valid),
    .seq_cur      (seq_cur)
);

// File: tb/seq_lcrc_framer_bench.sv
module seq_lcrc_framer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [31:0] POLY = 32'h04C11DB7;

    typedef struct packed {
        logic        rpl;
        logic        stall;
        logic        flip;
        logic [7:0]  len;
        logic [31:0] base;
        logic [11:0] rseq;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{1'b0, 1'b0, 1'b0, 8'd1, 32'h0000_0001, 12'h000},
        '{1'b0, 1'b1, 1'b0, 8'd4, 32'hDEAD_0000, 12'h000},
        '{1'b1, 1'b0, 1'b0, 8'd3, 32'h1234_0000, 12'h7FF},
        '{1'b0, 1'b0, 1'b1, 8'd2, 32'hA5A5_0000, 12'h000},
        '{1'b1, 1'b1, 1'b0, 8'd1, 32'h0000_0000, 12'hFFF},
        '{1'b0, 1'b1, 1'b0, 8'd5, 32'hFFFF_FFF0, 12'h000},
        '{1'b1, 1'b0, 1'b1, 8'd2, 32'h5555_0000, 12'h001},
        '{1'b0, 1'b0, 1'b0, 8'd3, 32'h0000_0000, 12'h000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        replay_mode = 1'b0;
    logic        new_valid = 1'b0, new_ready, new_sop = 1'b0, new_eop = 1'b0;
    logic [31:0] new_data = '0;
    logic        rpl_in_valid = 1'b0, rpl_in_ready, rpl_in_sop = 1'b0, rpl_in_eop = 1'b0;
    logic [31:0] rpl_in_data = '0;
    logic        out_valid, out_ready = 1'b1, out_sop, out_eop;
    logic [31:0] out_data;
    logic        store_valid, store_sop, store_eop;
    logic [31:0] store_data;

    seq_lcrc_framer u_seq_lcrc_framer (
        .clk(clk), .rst(rst), .replay_mode(replay_mode),
        .new_valid(new_valid), .new_ready(new_ready), .new_data(new_data),
        .new_sop(new_sop), .new_eop(new_eop),
        .rpl_in_valid(rpl_in_valid), .rpl_in_ready(rpl_in_ready),
        .rpl_in_data(rpl_in_data), .rpl_in_sop(rpl_in_sop), .rpl_in_eop(rpl_in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop),
        .store_valid(store_valid), .store_data(store_data),
        .store_sop(store_sop), .store_eop(store_eop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    logic [11:0] exp_seq = '0;

    logic [31:0] cap_d [0:15];
    logic        cap_s [0:15];
    logic        cap_e [0:15];
    int          ncap;
    logic [31:0] sto_d [0:15];
    logic        sto_s [0:15];
    logic        sto_e [0:15];
    int          nsto;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c,
                                            input logic [31:0] d, input int n);
        logic [31:0] r = c;
        for (int k = n - 1; k >= 0; k--) begin
            logic top = r[31] ^ d[k];
            r = r << 1;
            if (top) r = r ^ POLY;
        end
        return r;
    endfunction

    task automatic drive(input bit rpl, input int n, input logic [31:0] base,
                         input logic [11:0] rseq, input bit flip);
        int tot = rpl ? n + 1 : n;
        for (int i = 0; i < tot; i++) begin
            @(negedge clk);
            if (flip && i == 1) replay_mode = ~rpl;
            if (rpl) begin
                rpl_in_valid = 1'b1;
                rpl_in_data  = (i == 0) ? {20'h0, rseq} : base + 32'(i - 1);
                rpl_in_sop   = (i == 0);
                rpl_in_eop   = (i == tot - 1);
            end else begin
                new_valid = 1'b1;
                new_data  = base + 32'(i);
                new_sop   = (i == 0);
                new_eop   = (i == tot - 1);
            end
            #1;
            while (!(rpl ? rpl_in_ready : new_ready)) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        new_valid = 1'b0;
        rpl_in_valid = 1'b0;
    endtask

    task automatic collect(input bit stall);
        int          cyc = 0;
        bit          done = 0;
        bit          pend = 0;
        logic [31:0] pend_d = '0;
        ncap = 0;
        nsto = 0;
        while (!done) begin
            @(negedge clk);
            out_ready = stall ? (cyc % 3 == 2) : 1'b1;
            cyc++;
            #1;
            if (pend) chk(out_valid && out_data == pend_d, "R8", "held word", out_data, pend_d);
            pend = out_valid && !out_ready;
            pend_d = out_data;
            if (store_valid && nsto < 16) begin
                sto_d[nsto] = store_data; sto_s[nsto] = store_sop; sto_e[nsto] = store_eop;
                nsto++;
            end
            if (out_valid && out_ready) begin
                if (ncap < 16) begin
                    cap_d[ncap] = out_data; cap_s[ncap] = out_sop; cap_e[ncap] = out_eop;
                end
                ncap++;
                if (out_eop) done = 1;
            end
        end
        out_ready = 1'b1;
    endtask

    task automatic run_pkt(input bit rpl, input int n, input logic [31:0] base,
                           input logic [11:0] rseq, input bit stall, input bit flip);
        logic [31:0] hdr, c;
        bit ok;
        replay_mode = rpl;
        fork
            drive(rpl, n, base, rseq, flip);
            collect(stall);
        join
        hdr = rpl ? {20'h0, rseq} : {20'h0, exp_seq};
        chk(ncap == n + 2, "R2", "word count", 32'(ncap), 32'(n + 2));
        if (ncap == n + 2) begin
            chk(cap_d[0] == hdr && cap_s[0] && !cap_e[0],
                rpl ? "R6" : "R2 R4", "header", cap_d[0], hdr);
            ok = 1;
            for (int i = 1; i <= n; i++)
                if (cap_d[i] != base + 32'(i - 1) || cap_s[i] || cap_e[i]) ok = 0;
            chk(ok, flip ? "R7" : "R2", "body words", cap_d[1], base);
            c = ref_crc(32'hFFFF_FFFF, hdr, 16);
            for (int i = 0; i < n; i++) c = ref_crc(c, base + 32'(i), 32);
            chk(cap_d[n + 1] == ~c && cap_e[n + 1] && !cap_s[n + 1],
                stall ? "R3 R8" : "R3", "crc word", cap_d[n + 1], ~c);
        end
        if (rpl) begin
            chk(nsto == 0, "R6", "store copies", 32'(nsto), 32'd0);
        end else begin
            chk(nsto == n + 1, "R5", "store count", 32'(nsto), 32'(n + 1));
            if (nsto == n + 1) begin
                ok = (sto_d[0] == hdr) && sto_s[0] && !sto_e[0];
                for (int i = 1; i <= n; i++)
                    if (sto_d[i] != base + 32'(i - 1) || sto_s[i] || sto_e[i] != (i == n)) ok = 0;
                chk(ok, "R5", "store words", sto_d[0], hdr);
            end
            exp_seq = exp_seq + 12'd1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_seq = '0;
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle after reset
        chk(!out_valid && !store_valid, "R1", "idle after reset",
            {30'h0, out_valid, store_valid}, 32'h0);

        foreach (VEC[i])
            run_pkt(VEC[i].rpl, int'(VEC[i].len), VEC[i].base, VEC[i].rseq,
                    VEC[i].stall, VEC[i].flip);

        // R10: stray word without start flag between packets
        @(negedge clk);
        replay_mode = 1'b0;
        new_valid = 1'b1; new_sop = 1'b0; new_eop = 1'b1; new_data = 32'hBAD0_BAD0;
        #1;
        chk(new_ready && !out_valid && !store_valid, "R10", "stray word dropped",
            {29'h0, new_ready, out_valid, store_valid}, 32'h4);
        @(negedge clk);
        new_valid = 1'b0;
        run_pkt(1'b0, 2, 32'h0BAD_0001, 12'h0, 1'b0, 1'b0); // header shows R10 left seq alone

        // R8 and R9: header held while blocked, other source never ready
        @(negedge clk);
        out_ready = 1'b0;
        new_valid = 1'b1; new_sop = 1'b1; new_eop = 1'b1; new_data = 32'h7777_0000;
        rpl_in_valid = 1'b1; rpl_in_sop = 1'b1; rpl_in_data = 32'h0000_0ABC;
        #1;
        held = out_data;
        chk(out_valid && out_sop && held == {20'h0, exp_seq}, "R8", "blocked header",
            held, {20'h0, exp_seq});
        chk(!new_ready && !rpl_in_ready, "R9", "no ready while blocked",
            {30'h0, new_ready, rpl_in_ready}, 32'h0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(out_valid && out_data == held && !new_ready, "R8", "stable while blocked",
                out_data, held);
            chk(!rpl_in_ready, "R9", "replay source not ready", {31'h0, rpl_in_ready}, 32'h0);
        end
        @(negedge clk);
        new_valid = 1'b0; rpl_in_valid = 1'b0; rpl_in_sop = 1'b0;
        out_ready = 1'b1;

        // R1: reset in mid-run restores sequence 0
        do_reset();
        run_pkt(1'b0, 1, 32'hC0DE_0000, 12'h0, 1'b0, 1'b0);

        // R4: wrap after 4096 new packets
        do_reset();
        for (int p = 0; p < 4096; p++)
            run_pkt(1'b0, 1, 32'(p), 12'h0, 1'b0, 1'b0);
        chk(cap_d[0] == 32'h0000_0FFF, "R4", "last before wrap", cap_d[0], 32'h0000_0FFF);
        run_pkt(1'b0, 1, 32'h1111_1111, 12'h0, 1'b0, 1'b0);
        chk(cap_d[0] == 32'h0, "R4", "sequence wrapped", cap_d[0], 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < WATCHDOG; t++) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired: actual=%0d cycles expected=completion", WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule